// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two timer/counter units that share one byte-wide register port. Each unit advances on a machine-cycle tick. It counts in one of two ways: it counts every tick (timer), or it counts a falling transition on its count pin (counter). A gate option ties counting to a level on a second pin, so a unit can measure the width of a pulse. When a unit rolls over, it raises a sticky overflow flag. Software reads the flags and can clear or set them by writing the control register.

Each unit has four count layouts, chosen by a 2-bit mode field:
- Mode 0 is a 13-bit counter. It uses the full high byte plus the low five bits of the low byte.
- Mode 1 is a plain 16-bit counter.
- Mode 2 is an 8-bit counter with reload. On overflow the low byte reloads from the high byte.
- Mode 3 on unit 0 splits the unit into two independent 8-bit counters. The second of these borrows unit 1's run bit and flag. Mode 3 on unit 1 parks that unit.

The register map is as follows. Unsupported addresses read zero.

| Address | Register |
|---------|----------|
| 0 | mode register |
| 1 | control register |
| 2 | unit 0 low byte |
| 3 | unit 0 high byte |
| 4 | unit 1 low byte |
| 5 | unit 1 high byte |

Top module: `tmr_pair_top`

## Requirements
- R1: After reset, all registers read 0x00 and both bits of `ovf_flag` are low. Addresses 6 and 7 always read 0x00.
- R2: The mode register at address 0 reads back what was written. Bits 3:0 configure unit 0 and bits 7:4 configure unit 1. Within each nibble, bit 3 is gate, bit 2 selects counter, and bits 1:0 are the mode. The control register at address 1 holds the unit 1 flag in bit 7, the unit 1 run bit in bit 6, the unit 0 flag in bit 5 and the unit 0 run bit in bit 4. Bits 3:0 of the control register read 0. `ovf_flag` is {unit 1 flag, unit 0 flag}.
- R3: A unit advances by one on a cycle with `mc_tick` high only when its run bit is 1 and either its gate bit is 0 or its `gate_pin` is high. With the run bit at 0, the count holds.
- R4: In counter mode, a unit advances on a tick at which `ev_pin` is 0 and `ev_pin` was 1 at the previous tick. Pin changes between ticks are not counted.
- R5: In mode 0, {high byte, low byte[4:0]} counts as 13 bits and low byte[7:5] never changes from counting. A step from 0x1FFF to 0 sets the unit's flag.
- R6: In mode 1, the 16-bit count wraps from 0xFFFF to 0x0000 and sets the flag. Setting the run bit leaves the count unchanged.
- R7: In mode 2, the low byte counts. On a step from 0xFF it loads the high byte and sets the flag. Counting never changes the high byte.
- R8: When unit 1 is in mode 3, its count holds and its flag is not set by counting.
- R9: With unit 0 in mode 3, its low byte is an 8-bit counter under unit 0's run, gate, select and flag. Its high byte counts every tick while unit 1's run bit is 1, regardless of gate, and its wrap from 0xFF sets unit 1's flag.
- R10: While unit 0 is in mode 3, unit 1 in modes 0 to 2 counts without needing its run bit, and its overflow does not set unit 1's flag.
- R11: A write to a count byte in the same cycle as a step wins. In modes 0 to 2, a write to either byte of a unit cancels that unit's step. In the split mode, the write cancels only the step of the written half.
- R12: A control-register write loads both flags. An overflow set in the same cycle takes priority over a written 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mc_tick | input | 1 | One-cycle machine-cycle tick |
| ev_pin | input | 2 | Count pins, bit n for unit n |
| gate_pin | input | 2 | Gate-level pins, bit n for unit n |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | BYTE_W | Write data |
| reg_rdata | output | BYTE_W | Read data, combinational from reg_addr |
| ovf_flag | output | 2 | Overflow flags {unit 1, unit 0} |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a count step and a software write to a count byte. The bench raises `mc_tick` and a count-byte write together. It then checks that the written value stands and that the other byte did not take the carry.

The second pair is a hardware overflow and a software clear of that flag. The bench arranges a wrap on the very tick that writes 0 into the flag. It then checks that the flag reads as set afterwards, and that a later write with no wrap clears it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MD_PRE13   = 2'd0,
    MD_FULL16  = 2'd1,
    MD_RELOAD8 = 2'd2,
    MD_SPLIT   = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext;
    tmr_mode_e mode;
  } tmr_cfg_t;

  localparam int unsigned CFG_W  = 4;
  localparam int unsigned RA_MODE = 0;
  localparam int unsigned RA_CTRL = 1;
  localparam int unsigned RA_C0L  = 2;
  localparam int unsigned RA_C0H  = 3;
  localparam int unsigned RA_C1L  = 4;
  localparam int unsigned RA_C1H  = 5;

  // control register bit positions
  localparam int unsigned CB_RUN0  = 4;
  localparam int unsigned CB_FLAG0 = 5;
  localparam int unsigned CB_RUN1  = 6;
  localparam int unsigned CB_FLAG1 = 7;

endpackage

// File: rtl/tmr_trig.sv
module tmr_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cnt_pin,
  input  logic gate_pin,
  input  logic run,
  input  logic gate_sel,
  input  logic ext_sel,
  output logic step
);

  logic smp_q;
  logic smp_d;
  logic fall;

  always_comb begin
    smp_d = smp_q;
    if (tick) smp_d = cnt_pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= 1'b0;
    else        smp_q <= smp_d;
  end

  assign fall = smp_q & ~cnt_pin;

  always_comb begin
    step = tick & run & (~gate_sel | gate_pin) & (~ext_sel | fall);
  end

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned PRE_W    = 5,
  parameter bit          SPLIT_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         mode,
  input  logic              step,
  input  logic              hi_step,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              ovf,
  output logic              hi_ovf
);

  localparam int unsigned FULL_W = 2 * BYTE_W;
  localparam int unsigned PRE_CW = BYTE_W + PRE_W;

  logic [BYTE_W-1:0] lo_d, hi_d, lo_inc, hi_inc;
  logic [FULL_W-1:0] full, full_inc;
  logic [PRE_CW-1:0] pre, pre_inc;
  logic              any_wr;

  assign full     = {hi_q, lo_q};
  assign full_inc = full + 1'b1;
  assign pre      = {hi_q, lo_q[PRE_W-1:0]};
  assign pre_inc  = pre + 1'b1;
  assign lo_inc   = lo_q + 1'b1;
  assign hi_inc   = hi_q + 1'b1;
  assign any_wr   = wr_lo | wr_hi;

  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    ovf    = 1'b0;
    hi_ovf = 1'b0;
    unique case (mode)
      MD_PRE13: begin
        if (step && !any_wr) begin
          hi_d = pre_inc[PRE_CW-1:PRE_W];
          lo_d = {lo_q[BYTE_W-1:PRE_W], pre_inc[PRE_W-1:0]};
          ovf  = &pre;
        end
      end
      MD_FULL16: begin
        if (step && !any_wr) begin
          {hi_d, lo_d} = full_inc;
          ovf          = &full;
        end
      end
      MD_RELOAD8: begin
        if (step && !any_wr) begin
          if (&lo_q) begin
            lo_d = hi_q;
            ovf  = 1'b1;
          end else begin
            lo_d = lo_inc;
          end
        end
      end
      MD_SPLIT: begin
        if (SPLIT_OK) begin
          if (step && !wr_lo) begin
            lo_d = lo_inc;
            ovf  = &lo_q;
          end
          if (hi_step && !wr_hi) begin
            hi_d   = hi_inc;
            hi_ovf = &hi_q;
          end
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_d = wdata;
    if (wr_hi) hi_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

endmodule

// File: rtl/tmr_pair_top.sv
module tmr_pair_top
  import tmr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PRE_W  = 5,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick,
  input  logic [1:0]        ev_pin,
  input  logic [1:0]        gate_pin,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic [1:0]        ovf_flag
);

  localparam int unsigned N_UNIT = 2;
  localparam int unsigned MODE_W = N_UNIT * CFG_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic [MODE_W-1:0] mode_q, mode_d;
  logic [N_UNIT-1:0] run_q, run_d, flag_q, flag_d;
  logic              wr_mode, wr_ctrl;
  tmr_cfg_t          cfg [N_UNIT];
  logic              split0;
  logic [N_UNIT-1:0] run_eff, step, ovf, hi_ovf;
  logic [BYTE_W-1:0] lo_cnt [N_UNIT];
  logic [BYTE_W-1:0] hi_cnt [N_UNIT];

  assign wr_mode = reg_we && (reg_addr == ADDR_W'(RA_MODE));
  assign wr_ctrl = reg_we && (reg_addr == ADDR_W'(RA_CTRL));
  assign split0  = (cfg[0].mode == MD_SPLIT);

  generate
    for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
      logic wr_lo_u, wr_hi_u, hi_step_u;

      assign cfg[u]     = tmr_cfg_t'(mode_q[u*CFG_W +: CFG_W]);
      assign wr_lo_u    = reg_we && (reg_addr == ADDR_W'(RA_C0L + 2*u));
      assign wr_hi_u    = reg_we && (reg_addr == ADDR_W'(RA_C0H + 2*u));
      assign run_eff[u] = (u == 1 && split0) ? 1'b1 : run_q[u];
      assign hi_step_u  = (u == 0) ? (mc_tick & run_q[1]) : 1'b0;

      tmr_trig u_trig (
        .clk      (clk),
        .rst_n    (rst_s),
        .tick     (mc_tick),
        .cnt_pin  (ev_pin[u]),
        .gate_pin (gate_pin[u]),
        .run      (run_eff[u]),
        .gate_sel (cfg[u].gate),
        .ext_sel  (cfg[u].ext),
        .step     (step[u])
      );

      tmr_unit #(
        .BYTE_W   (BYTE_W),
        .PRE_W    (PRE_W),
        .SPLIT_OK (u == 0)
      ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_s),
        .mode    (cfg[u].mode),
        .step    (step[u]),
        .hi_step (hi_step_u),
        .wr_lo   (wr_lo_u),
        .wr_hi   (wr_hi_u),
        .wdata   (reg_wdata),
        .lo_q    (lo_cnt[u]),
        .hi_q    (hi_cnt[u]),
        .ovf     (ovf[u]),
        .hi_ovf  (hi_ovf[u])
      );
    end
  endgenerate

  // next state for mode, run and flag registers
  always_comb begin
    mode_d = mode_q;
    run_d  = run_q;
    flag_d = flag_q;
    if (wr_mode) mode_d = reg_wdata[MODE_W-1:0];
    if (wr_ctrl) begin
      run_d  = {reg_wdata[CB_RUN1],  reg_wdata[CB_RUN0]};
      flag_d = {reg_wdata[CB_FLAG1], reg_wdata[CB_FLAG0]};
    end
    if (ovf[0]) flag_d[0] = 1'b1;
    if (split0 ? hi_ovf[0] : (ovf[1] | hi_ovf[1])) flag_d[1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      mode_q <= mode_d;
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (int'(reg_addr))
      RA_MODE: reg_rdata = BYTE_W'(mode_q);
      RA_CTRL: begin
        reg_rdata[CB_RUN0]  = run_q[0];
        reg_rdata[CB_FLAG0] = flag_q[0];
        reg_rdata[CB_RUN1]  = run_q[1];
        reg_rdata[CB_FLAG1] = flag_q[1];
      end
      RA_C0L:  reg_rdata = lo_cnt[0];
      RA_C0H:  reg_rdata = hi_cnt[0];
      RA_C1L:  reg_rdata = lo_cnt[1];
      RA_C1H:  reg_rdata = hi_cnt[1];
      default: reg_rdata = '0;
    endcase
  end

  assign ovf_flag = flag_q;

endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PRE_W  = 5,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_s,
  input logic [7:0]        mode_q,
  input logic [1:0]        run_q,
  input logic [1:0]        flag_q,
  input logic [1:0]        step,
  input logic [BYTE_W-1:0] lo0,
  input logic [BYTE_W-1:0] hi0,
  input logic [BYTE_W-1:0] lo1,
  input logic [BYTE_W-1:0] hi1,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [BYTE_W-1:0] reg_wdata
);

  logic w0l, w0h, w1l, w1h;
  assign w0l = reg_we && (reg_addr == ADDR_W'(2));
  assign w0h = reg_we && (reg_addr == ADDR_W'(3));
  assign w1l = reg_we && (reg_addr == ADDR_W'(4));
  assign w1h = reg_we && (reg_addr == ADDR_W'(5));

  AST_WRAP16_FLAG: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_q[1:0] == 2'd1 && step[0] && (&{hi0, lo0}) && !w0l && !w0h) |=> flag_q[0]); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    (!run_q[0] && mode_q[1:0] != 2'd3 && !w0l && !w0h) |=> $stable({hi0, lo0})); // R3

  AST_RELOAD_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_q[1:0] == 2'd2 && !w0h) |=> $stable(hi0)); // R7

  AST_T1_PARKED: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_q[5:4] == 2'd3 && !w1l && !w1h) |=> $stable({hi1, lo1})); // R8

  AST_PRE_TOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_s)
    (mode_q[1:0] == 2'd0 && !w0l) |=> $stable(lo0[BYTE_W-1:PRE_W])); // R5

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_s)
    w0l |=> (lo0 == $past(reg_wdata))); // R11

endmodule

bind tmr_pair_top tmr_pair_chk #(
  .BYTE_W (BYTE_W),
  .PRE_W  (PRE_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .mode_q    (mode_q[7:0]),
  .run_q     (run_q),
  .flag_q    (flag_q),
  .step      (step),
  .lo0       (lo_cnt[0]),
  .hi0       (hi_cnt[0]),
  .lo1       (lo_cnt[1]),
  .hi1       (hi_cnt[1]),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata)
);

// File: tb/sim_tmr_pair_top.sv
`timescale 1ns/1ps
module sim_tmr_pair_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_tick = 1'b0;
  logic [1:0] ev_pin = 2'b00;
  logic [1:0] gate_pin = 2'b00;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [1:0] ovf_flag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_pair_top u0 (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .ev_pin(ev_pin),
    .gate_pin(gate_pin), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); mc_tick = 1'b1;
      @(negedge clk); mc_tick = 1'b0;
    end
  endtask

  task automatic tk_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    mc_tick = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    mc_tick = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic set_cnt(input int u, input logic [7:0] lo, input logic [7:0] hi);
    wr(3'(2 + 2*u), lo);
    wr(3'(3 + 2*u), hi);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1", $sformatf("addr %0d after reset", a), v, 0);
    end
    chk("R1", "flags after reset", ovf_flag, 0);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(3'd0, 8'hA5); rd(3'd0, v); chk("R2", "mode readback", v, 8'hA5);
    wr(3'd1, 8'hFF); rd(3'd1, v); chk("R2", "ctrl readback", v, 8'hF0);
    chk("R2", "flag pins from ctrl", ovf_flag, 2'b11);
    wr(3'd5, 8'h3C); rd(3'd5, v); chk("R2", "unit1 high readback", v, 8'h3C);
    wr(3'd6, 8'h77); rd(3'd6, v); chk("R1", "spare address", v, 0);
    wr(3'd1, 8'h00); rd(3'd1, v); chk("R12", "software flag clear", v, 0);
    wr(3'd0, 8'h00); set_cnt(1, 8'h00, 8'h00);
  endtask

  task automatic t_gate;
    logic [7:0] v;
    wr(3'd0, 8'h09); set_cnt(0, 8'h00, 8'h00); wr(3'd1, 8'h10);
    gate_pin[0] = 1'b0; tk(3); rd(3'd2, v); chk("R3", "gate pin low blocks", v, 0);
    gate_pin[0] = 1'b1; tk(3); rd(3'd2, v); chk("R3", "gate pin high counts", v, 3);
    wr(3'd1, 8'h00); tk(2); rd(3'd2, v); chk("R3", "run off holds", v, 3);
    wr(3'd1, 8'h10); rd(3'd2, v); chk("R6", "run set keeps count", v, 3);
    wr(3'd1, 8'h00); gate_pin[0] = 1'b0;
  endtask

  task automatic t_counter;
    logic [7:0] v;
    wr(3'd0, 8'h05); set_cnt(0, 8'h00, 8'h00); wr(3'd1, 8'h10);
    ev_pin[0] = 1'b1; tk(1); rd(3'd2, v); chk("R4", "high sample no count", v, 0);
    ev_pin[0] = 1'b0; tk(1); rd(3'd2, v); chk("R4", "falling step counts", v, 1);
    tk(1); rd(3'd2, v); chk("R4", "steady low no count", v, 1);
    ev_pin[0] = 1'b1; tk(1); ev_pin[0] = 1'b0; tk(1);
    rd(3'd2, v); chk("R4", "second fall", v, 2);
    @(negedge clk); ev_pin[0] = 1'b1; @(negedge clk); @(negedge clk); ev_pin[0] = 1'b0;
    tk(1); rd(3'd2, v); chk("R4", "pulse between ticks ignored", v, 2);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_mode0;
    logic [7:0] v;
    wr(3'd0, 8'h00); set_cnt(0, 8'h1F, 8'h00); wr(3'd1, 8'h10);
    tk(1); rd(3'd2, v); chk("R5", "prescale wrap low", v, 8'h00);
    rd(3'd3, v); chk("R5", "carry into high", v, 8'h01);
    set_cnt(0, 8'hFE, 8'hFF);
    tk(1); rd(3'd2, v); chk("R5", "low at 1FFF", v, 8'hFF);
    chk("R5", "no flag before wrap", ovf_flag, 0);
    tk(1); rd(3'd2, v); chk("R5", "upper bits kept on wrap", v, 8'hE0);
    rd(3'd3, v); chk("R5", "high after wrap", v, 8'h00);
    chk("R5", "flag on 13-bit wrap", ovf_flag, 2'b01);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_mode1;
    logic [7:0] v;
    wr(3'd0, 8'h01); set_cnt(0, 8'hFF, 8'h12); wr(3'd1, 8'h10);
    tk(1); rd(3'd2, v); chk("R6", "16-bit carry low", v, 0);
    rd(3'd3, v); chk("R6", "16-bit carry high", v, 8'h13);
    chk("R6", "no flag mid count", ovf_flag, 0);
    set_cnt(0, 8'hFF, 8'hFF); tk(1);
    rd(3'd3, v); chk("R6", "wrap to zero", v, 0);
    chk("R6", "flag on 16-bit wrap", ovf_flag, 2'b01);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_mode2;
    logic [7:0] v;
    wr(3'd0, 8'h02); set_cnt(0, 8'hFE, 8'h80); wr(3'd1, 8'h10);
    tk(1); rd(3'd2, v); chk("R7", "low counts", v, 8'hFF);
    tk(1); rd(3'd2, v); chk("R7", "reload from high", v, 8'h80);
    rd(3'd3, v); chk("R7", "high unchanged", v, 8'h80);
    chk("R7", "flag on reload", ovf_flag, 2'b01);
    tk(1); rd(3'd2, v); chk("R7", "counts after reload", v, 8'h81);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_t1_park;
    logic [7:0] v;
    wr(3'd0, 8'h30); set_cnt(1, 8'h05, 8'h06); wr(3'd1, 8'h40);
    tk(3); rd(3'd4, v); chk("R8", "unit1 low parked", v, 8'h05);
    rd(3'd5, v); chk("R8", "unit1 high parked", v, 8'h06);
    chk("R8", "no flags", ovf_flag, 0);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_split;
    logic [7:0] v;
    wr(3'd1, 8'h00); wr(3'd0, 8'h13);
    set_cnt(0, 8'hFE, 8'hFF); set_cnt(1, 8'h00, 8'h00);
    wr(3'd1, 8'h10);
    tk(1); rd(3'd2, v); chk("R9", "split low counts", v, 8'hFF);
    rd(3'd3, v); chk("R9", "split high waits for run1", v, 8'hFF);
    rd(3'd4, v); chk("R10", "unit1 counts without run1", v, 8'h01);
    tk(1); rd(3'd2, v); chk("R9", "split low wraps", v, 8'h00);
    chk("R9", "split low sets flag0", ovf_flag, 2'b01);
    wr(3'd1, 8'h40);
    tk(1); rd(3'd3, v); chk("R9", "split high wraps under run1", v, 8'h00);
    rd(3'd2, v); chk("R9", "split low idle with run0 off", v, 8'h00);
    chk("R9", "split high sets flag1", ovf_flag, 2'b10);
    wr(3'd1, 8'h00); set_cnt(1, 8'hFF, 8'hFF);
    tk(1); rd(3'd5, v); chk("R10", "unit1 wrapped", v, 8'h00);
    chk("R10", "unit1 wrap leaves flag1 low", ovf_flag, 0);
  endtask

  task automatic t_write_prio;
    logic [7:0] v;
    wr(3'd0, 8'h01); set_cnt(0, 8'h10, 8'h00); wr(3'd1, 8'h10);
    tk_wr(3'd2, 8'h55); rd(3'd2, v); chk("R11", "write beats step", v, 8'h55);
    tk(1); rd(3'd2, v); chk("R11", "counting resumes", v, 8'h56);
    set_cnt(0, 8'hFF, 8'h00);
    tk_wr(3'd3, 8'h20); rd(3'd2, v); chk("R11", "high write cancels low step", v, 8'hFF);
    rd(3'd3, v); chk("R11", "high write value", v, 8'h20);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_flag_prio;
    logic [7:0] v;
    wr(3'd0, 8'h01); set_cnt(0, 8'hFF, 8'hFF); wr(3'd1, 8'h10);
    tk_wr(3'd1, 8'h10);
    chk("R12", "overflow beats clear", ovf_flag, 2'b01);
    wr(3'd1, 8'h10);
    chk("R12", "later clear works", ovf_flag, 0);
    wr(3'd1, 8'h20); rd(3'd1, v);
    chk("R12", "software sets flag", v, 8'h20);
    wr(3'd1, 8'h00);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_regs;
    t_gate;
    t_counter;
    t_mode0;
    t_mode1;
    t_mode2;
    t_t1_park;
    t_split;
    t_write_prio;
    t_flag_prio;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule